// File: doc/BRIEF.md
# Supply Supervisor Reset Timer

This block is the clocked timing core of a supply supervisor. It watches a flag from an external threshold comparator that reports whether the supply is above its trip level. It also watches an active-low push-button input. While either one calls for reset, the block holds its reset outputs asserted. When both have been quiet for one full hold interval, it releases the reset outputs. The hold interval is long, nominally 200 ms, so it also serves as the debounce for a mechanical button.

Both inputs pass through a two-flop synchronizer and then drive a three-state sequencer. In WAIT_SUPPLY the reset is held. The sequencer takes transition T_START to HOLD_COUNT once the synchronized supply flag is high and the button is released. From HOLD_COUNT it takes T_EXPIRE to RELEASED when the hold timer finishes. From HOLD_COUNT or RELEASED it takes T_ABORT back to WAIT_SUPPLY whenever the supply drops or the button is pressed. A fresh T_START therefore always begins a complete new interval. An asynchronous power-on clear forces WAIT_SUPPLY and clears the timer and the synchronizers. Reset is driven in two polarities that always move together, and a two-bit phase output reports the current state.

Top module: `por_pulse_gen`

## Requirements
- R1: With supply_ok low at the input, rst_hi_o is high within 3 rising clock edges, and it stays high for as long as supply_ok stays low.
- R2: If por_n, supply_ok and man_rst_n are all high after their last change, rst_hi_o stays high through HOLD_TICKS+2 rising edges after that change and falls on edge HOLD_TICKS+3.
- R3: If supply_ok drops during the hold interval, the elapsed count is discarded. After supply_ok recovers, the release comes a full HOLD_TICKS+3 edges later.
- R4: Driving man_rst_n low sets rst_hi_o high within 3 rising edges, whatever the state of the supply.
- R5: Releasing man_rst_n starts a complete new hold interval with the same timing as R2.
- R6: A man_rst_n low pulse lasting one clock, given during the hold interval or after release, restarts the full interval. There is no separate debounce filter.
- R7: rst_lo_n_o is always the complement of rst_hi_o.
- R8: por_n low asynchronously forces rst_hi_o high and phase_o to 00 with no clock edge needed. After por_n returns high, release follows the timing of R2.
- R9: phase_o is 00 while waiting for the supply or the button, 01 while counting the hold interval, and 10 once released. The value 11 never appears. rst_hi_o is high exactly when phase_o is not 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running time base |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok | input | 1 | Comparator flag, high when the supply is above threshold |
| man_rst_n | input | 1 | Push-button reset request, active low |
| rst_hi_o | output | 1 | Reset, active high |
| rst_lo_n_o | output | 1 | Reset, active low |
| phase_o | output | 2 | Sequencer phase: 00 wait, 01 hold, 10 released |

## Verification
Most internal faults surface at the ports within a few edges, and only one kind stays hidden longer. A sequencer stuck in the wrong state shows up on phase_o at the next sampling point, and the reset polarity on both outputs follows from it. A hold timer that keeps its old count across an abort, or that ends one tick early or late, stays hidden until the release edge. That edge then lands off the exact HOLD_TICKS+3 boundary, so each release is sampled on both sides of that boundary. A synchronizer with the wrong depth or reset value moves every boundary by a cycle, and the reset-state and power-on-clear checks catch that.

// File: rtl/por_pkg.sv
`timescale 1ns/1ps
package por_pkg;
    typedef enum logic [1:0] {
        PH_WAIT = 2'b00,
        PH_HOLD = 2'b01,
        PH_RUN  = 2'b10
    } phase_t;
endpackage

// File: rtl/por_sync.sv
`timescale 1ns/1ps
module por_sync #(
    parameter int          WIDTH   = 2,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge por_n) begin
                if (!por_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/por_hold_timer.sv
`timescale 1ns/1ps
module por_hold_timer #(
    parameter int HOLD_TICKS = 20_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/por_seq_fsm.sv
`timescale 1ns/1ps
module por_seq_fsm
    import por_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       sup_ok_i,
    input  logic       btn_n_i,
    input  logic       done_i,
    output logic       run_o,
    output logic       rst_hi_o,
    output logic       rst_lo_n_o,
    output logic [1:0] phase_o
);
    phase_t state_q, state_d;
    logic   quiet;

    assign quiet = sup_ok_i && btn_n_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_WAIT: if (quiet)  state_d = PH_HOLD;      // T_START
            PH_HOLD: begin
                if (!quiet)      state_d = PH_WAIT;      // T_ABORT
                else if (done_i) state_d = PH_RUN;       // T_EXPIRE
            end
            PH_RUN:  if (!quiet) state_d = PH_WAIT;      // T_ABORT
            default:             state_d = PH_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= PH_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o      = 1'b0;
        rst_hi_o   = 1'b1;
        rst_lo_n_o = 1'b0;
        unique case (state_q)
            PH_WAIT: ;
            PH_HOLD: run_o = 1'b1;
            PH_RUN: begin
                rst_hi_o   = 1'b0;
                rst_lo_n_o = 1'b1;
            end
            default: ;
        endcase
        phase_o = state_q;
    end
endmodule

// File: rtl/por_pulse_gen.sv
`timescale 1ns/1ps
module por_pulse_gen #(
    parameter int HOLD_TICKS  = 20_000_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       supply_ok,
    input  logic       man_rst_n,
    output logic       rst_hi_o,
    output logic       rst_lo_n_o,
    output logic [1:0] phase_o
);
    logic [1:0] raw_in, sync_out;
    logic       sup_ok_s, mr_n_s;
    logic       tmr_run, tmr_done;

    assign raw_in = {man_rst_n, supply_ok};

    por_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .d_i   (raw_in),
        .q_o   (sync_out)
    );

    assign sup_ok_s = sync_out[0];
    assign mr_n_s   = sync_out[1];

    por_hold_timer #(
        .HOLD_TICKS (HOLD_TICKS)
    ) u_timer (
        .clk    (clk),
        .por_n  (por_n),
        .run_i  (tmr_run),
        .done_o (tmr_done)
    );

    por_seq_fsm u_fsm (
        .clk        (clk),
        .por_n      (por_n),
        .sup_ok_i   (sup_ok_s),
        .btn_n_i    (mr_n_s),
        .done_i     (tmr_done),
        .run_o      (tmr_run),
        .rst_hi_o   (rst_hi_o),
        .rst_lo_n_o (rst_lo_n_o),
        .phase_o    (phase_o)
    );
endmodule

// File: rtl/por_pulse_gen_chk.sv
`timescale 1ns/1ps
module por_pulse_gen_chk #(
    parameter int HOLD_TICKS = 20_000_000
) (
    input logic       clk,
    input logic       por_n,
    input logic       sup_s,
    input logic       mr_s,
    input logic       rst_hi,
    input logic       rst_lo_n,
    input logic [1:0] phase
);
    logic [31:0] hold_seen;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              hold_seen <= '0;
        else if (phase == 2'b01) hold_seen <= hold_seen + 1;
        else                     hold_seen <= '0;
    end

    assert_supply_low_R1: assert property (@(posedge clk) disable iff (!por_n)
        !sup_s |=> (rst_hi && phase == 2'b00));

    assert_hold_length_R2: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_hi) |-> (hold_seen == 32'(HOLD_TICKS)));

    assert_button_forces_R4: assert property (@(posedge clk) disable iff (!por_n)
        !mr_s |=> (rst_hi && phase == 2'b00));

    assert_polarity_pair_R7: assert property (@(posedge clk) disable iff (!por_n)
        rst_lo_n == !rst_hi);

    assert_phase_legal_R9: assert property (@(posedge clk) disable iff (!por_n)
        phase != 2'b11);

    assert_release_only_from_hold_R9: assert property (@(posedge clk) disable iff (!por_n)
        $rose(phase == 2'b10) |-> $past(phase) == 2'b01);
endmodule

bind por_pulse_gen por_pulse_gen_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk      (clk),
    .por_n    (por_n),
    .sup_s    (sup_ok_s),
    .mr_s     (mr_n_s),
    .rst_hi   (rst_hi_o),
    .rst_lo_n (rst_lo_n_o),
    .phase    (phase_o)
);

// File: tb/tb_por_pulse_gen.sv
`timescale 1ns/1ps
module tb_por_pulse_gen;
    localparam int N = 16;

    logic       clk = 1'b0;
    logic       por_n, supply_ok, man_rst_n;
    logic       rst_hi_o, rst_lo_n_o;
    logic [1:0] phase_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    por_pulse_gen #(.HOLD_TICKS(N), .SYNC_STAGES(2)) dut (
        .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
        .rst_hi_o(rst_hi_o), .rst_lo_n_o(rst_lo_n_o), .phase_o(phase_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic chk_state(input string req, input logic hi, input logic [1:0] ph);
        chk(req, "rst_hi_o", 32'(rst_hi_o), 32'(hi));
        chk(req, "rst_lo_n_o", 32'(rst_lo_n_o), 32'(!hi));
        chk(req, "phase_o", 32'(phase_o), 32'(ph));
    endtask

    // Inputs were changed at a falling edge just before this call.
    task automatic expect_release(input string req);
        repeat (N + 2) @(posedge clk);
        @(negedge clk);
        chk_state(req, 1'b1, 2'b01);
        @(posedge clk);
        @(negedge clk);
        chk_state(req, 1'b0, 2'b10);
    endtask

    task automatic t_reset_state;
        por_n = 1'b0; supply_ok = 1'b0; man_rst_n = 1'b1;
        #1;
        chk_state("R8", 1'b1, 2'b00);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_state("R8", 1'b1, 2'b00);
        por_n = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk_state("R1", 1'b1, 2'b00);
    endtask

    task automatic t_power_up;
        supply_ok = 1'b1;
        expect_release("R2");
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk_state("R9", 1'b0, 2'b10);
    endtask

    task automatic t_supply_drop_released;
        supply_ok = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_state("R1", 1'b0, 2'b10);
        @(posedge clk);
        @(negedge clk);
        chk_state("R1", 1'b1, 2'b00);
        supply_ok = 1'b1;
        expect_release("R2");
    endtask

    task automatic t_brownout_mid_hold;
        supply_ok = 1'b0;
        repeat (4) @(negedge clk);
        supply_ok = 1'b1;
        repeat (10) @(negedge clk);
        chk_state("R3", 1'b1, 2'b01);
        supply_ok = 1'b0;
        repeat (2) @(negedge clk);
        supply_ok = 1'b1;
        expect_release("R3");
    endtask

    task automatic t_button;
        man_rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_state("R4", 1'b1, 2'b00);
        repeat (N * 2) @(negedge clk);
        chk_state("R4", 1'b1, 2'b00);
        man_rst_n = 1'b1;
        expect_release("R5");
    endtask

    task automatic t_button_bounce;
        repeat (6) @(negedge clk);
        man_rst_n = 1'b0;
        @(negedge clk);
        man_rst_n = 1'b1;
        @(negedge clk);
        man_rst_n = 1'b0;
        @(negedge clk);
        man_rst_n = 1'b1;
        expect_release("R6");
        repeat (8) @(negedge clk);
        man_rst_n = 1'b0;
        @(negedge clk);
        man_rst_n = 1'b1;
        expect_release("R6");
    endtask

    task automatic t_button_supply_low;
        supply_ok = 1'b0;
        man_rst_n = 1'b0;
        repeat (5) @(negedge clk);
        man_rst_n = 1'b1;
        repeat (N + 6) @(negedge clk);
        chk_state("R1", 1'b1, 2'b00);
        supply_ok = 1'b1;
        expect_release("R2");
    endtask

    task automatic t_async_clear;
        repeat (3) @(negedge clk);
        #2;
        por_n = 1'b0;
        #1;
        chk_state("R8", 1'b1, 2'b00);
        @(negedge clk);
        por_n = 1'b1;
        expect_release("R8");
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done_flag) begin
            done_flag = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_power_up();
        t_supply_drop_released();
        t_brownout_mid_hold();
        t_button();
        t_button_bounce();
        t_button_supply_low();
        t_async_clear();
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule